// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to twelve interrupt sources and turns them into a single prioritized request for a small processor core. Each source owns a pending flag that is set by a one-cycle event pulse. The flag stays set until the core services that source or the block is reset. Two byte-wide enable registers mask the sources individually. A global enable bit, kept inside the block, gates the request line. The core drives that bit through disable, enable and return-from-interrupt strobes.

When the core acknowledges a request, three things happen in the same clock edge. The global enable drops. Only the winning source's pending flag is cleared. The winner's vector address, twice its source number, is what `irq_vec` presented in the acknowledge cycle. A small register port lets firmware do four things: write and read the enable masks, read the vector of the best enabled pending source, and read a status byte. The status byte holds an IRQ-sense bit that reports enabled pending work even while the global enable is off.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A pending flag is set by its source's event pulse at the next clock edge and stays set until that source is acknowledged or reset is applied.
- R2: While `rst_n` is low, and right after it rises, all pending flags, both enable masks and the global enable are zero. `irq_req` is 0 and every register address reads 0x00.
- R3: A pending source contributes to `irq_req`, to the vector and to IRQ-sense only when its mask bit is 1. Source n (1..12) is mask bit n-1 of the 12-bit mask. Address 0 holds sources 1..8 in bits 7:0, and address 1 holds sources 9..12 in bits 3:0.
- R4: Priority is fixed: the lowest-numbered enabled pending source wins. `irq_vec` is 2*n for winner n (0x0002..0x0018), or 0 when no enabled source is pending.
- R5: An acknowledge accepted at a clock edge clears the global enable and the winner's pending flag at that edge. Every other pending flag is left unchanged.
- R6: `irq_req` is 1 exactly when the global enable is 1 and at least one enabled source is pending. An `irq_ack` while `irq_req` is 0 changes nothing.
- R7: Address 2 (read-only vector register) returns the winner number in bits 4:1, 0 in bit 0, and 0 in bits 7:5. It reads 0x00 when no enabled source is pending.
- R8: Address 3 (read-only status) returns IRQ-sense in bit 7, meaning any enabled source is pending regardless of the global enable. It returns the global enable in bit 2 and 0 elsewhere.
- R9: `dis_stb` clears the global enable, and `en_stb` or `reti_stb` sets it. These strobes touch neither the masks nor the pending flags. An accepted acknowledge or `dis_stb` takes precedence over `en_stb` and `reti_stb` in the same cycle.
- R10: If a source's event arrives in the same cycle that the acknowledge clears its flag, the flag stays set.
- R11: Writes to addresses 2 and 3 have no effect. Bits 7:4 of address 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 12 | Event pulses, bit n-1 for source n |
| irq_ack | input | 1 | Acknowledge from the core |
| dis_stb | input | 1 | Clear global enable |
| en_stb | input | 1 | Set global enable |
| reti_stb | input | 1 | Return from interrupt, sets global enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0,1 masks; 2 vector; 3 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of current winner |

## Verification
The bench aims at the acknowledge edge. A design that clears every pending flag on acknowledge loses a lower-priority source. A design that lets the clear beat a same-cycle event on the serviced source (R10) silently drops an interrupt. It also checks masked sources that are pending before their mask bit is set: they must appear in the status and vector registers only after the write, and must not raise a request while the global enable is off. Strobe collisions (enable against disable, return against acknowledge) and acknowledges with no request outstanding are driven directly and also appear in the random traffic. An error there would leave the core with interrupts enabled inside a handler, or would clear a flag nobody serviced.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned MAX_SRC = 15;
  localparam int unsigned REG_W   = 8;

  typedef enum logic [1:0] {
    RA_MASK_LO = 2'd0,
    RA_MASK_HI = 2'd1,
    RA_VECTOR  = 2'd2,
    RA_STATUS  = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_SENSE_BIT = 7;
  localparam int unsigned ST_GIE_BIT   = 2;

  // vector address for a 1-based source number
  function automatic logic [15:0] vec_addr(input logic [3:0] num);
    return {11'd0, num, 1'b0};
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NSRC = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] pend_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      pend_q[g] <= 1'b0;
      else if (evt[g]) pend_q[g] <= 1'b1;
      else if (clr_mask[g]) pend_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NSRC  = 12,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  req_vec,
  output logic             any,
  output logic [IDX_W-1:0] win_idx,
  output logic [NSRC-1:0]  win_mask
);
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign any      = |req_vec;
  assign win_mask = any ? (NSRC'(1) << win_idx) : '0;
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_fire,
  input  logic dis_stb,
  input  logic en_stb,
  input  logic reti_stb,
  output logic gie_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     gie_q <= 1'b0;
    else if (ack_fire || dis_stb)   gie_q <= 1'b0;
    else if (en_stb || reti_stb)    gie_q <= 1'b1;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NSRC = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            irq_ack,
  input  logic            dis_stb,
  input  logic            en_stb,
  input  logic            reti_stb,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            irq_req,
  output logic [15:0]     irq_vec
);
  localparam int unsigned IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  live_req;
  logic [NSRC-1:0]  win_mask;
  logic [NSRC-1:0]  clr_mask;
  logic [IDX_W-1:0] win_idx;
  logic             sense;
  logic             gie_q;
  logic             ack_fire;
  logic [15:0]      mask_pad;
  logic [3:0]       win_num;

  // enable masks, byte-split across two addresses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NSRC; i++) begin
        if (reg_addr == 2'(i / 8)) mask_q[i] <= reg_wdata[i % 8];
      end
    end
  end

  assign live_req = pend_q & mask_q;
  assign ack_fire = irq_ack && irq_req;
  assign clr_mask = ack_fire ? win_mask : '0;

  irq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(src_evt), .clr_mask(clr_mask), .pend_q(pend_q)
  );

  irq_prio_pick #(.NSRC(NSRC)) u_pick (
    .req_vec(live_req), .any(sense), .win_idx(win_idx), .win_mask(win_mask)
  );

  irq_gie_ctl u_gie (
    .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .dis_stb(dis_stb),
    .en_stb(en_stb), .reti_stb(reti_stb), .gie_q(gie_q)
  );

  assign win_num = sense ? (4'(win_idx) + 4'd1) : 4'd0;
  assign irq_req = gie_q && sense;
  assign irq_vec = vec_addr(win_num);

  always_comb begin
    mask_pad = '0;
    mask_pad[NSRC-1:0] = mask_q;
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr))
      RA_MASK_LO: reg_rdata = mask_pad[7:0];
      RA_MASK_HI: reg_rdata = mask_pad[15:8];
      RA_VECTOR:  reg_rdata = irq_vec[7:0];
      default: begin
        reg_rdata = '0;
        reg_rdata[ST_SENSE_BIT] = sense;
        reg_rdata[ST_GIE_BIT]   = gie_q;
      end
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned NSRC = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_evt,
  input logic            irq_ack,
  input logic            irq_req,
  input logic [15:0]     irq_vec,
  input logic            dis_stb,
  input logic            en_stb,
  input logic            reti_stb,
  input logic [NSRC-1:0] pend_q,
  input logic            gie_q,
  input logic            ack_fire
);
  p_hold_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fire |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_ack_drops_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !gie_q);

  p_ack_single_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> ($countones($past(pend_q) & ~pend_q) <= 1));

  p_ignored_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req) |=> (pend_q == ($past(pend_q) | $past(src_evt))));

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

  p_strobe_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_stb || reti_stb) && !dis_stb && !(irq_ack && irq_req)) |=> gie_q);

  p_vec_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[0] == 1'b0 && irq_vec != 16'd0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .irq_ack(irq_ack),
  .irq_req(irq_req), .irq_vec(irq_vec), .dis_stb(dis_stb), .en_stb(en_stb),
  .reti_stb(reti_stb), .pend_q(pend_q), .gie_q(gie_q), .ack_fire(ack_fire)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic irq_ack = 0, dis_stb = 0, en_stb = 0, reti_stb = 0, reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_req;
  logic [15:0] irq_vec;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model state
  logic [N-1:0] m_pend = '0, m_mask = '0;
  logic m_gie = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl #(.NSRC(N)) u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .irq_ack(irq_ack),
    .dis_stb(dis_stb), .en_stb(en_stb), .reti_stb(reti_stb), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic int best_src(input logic [N-1:0] p, input logic [N-1:0] m);
    for (int n = 1; n <= N; n++) if (p[n-1] && m[n-1]) return n;
    return 0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    int w = best_src(m_pend, m_mask);
    case (a)
      2'd0: return m_mask[7:0];
      2'd1: return {4'd0, m_mask[11:8]};
      2'd2: return 8'(w * 2);
      default: return {(w != 0), 4'd0, m_gie, 2'd0};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, {8'd0, reg_rdata}, {8'd0, exp});
  endtask

  // one cycle: drive at negedge, check, clock, update model
  task automatic step(input logic [N-1:0] evt, input logic ack, input logic dis,
                      input logic en, input logic rt, input logic wr,
                      input logic [1:0] a, input logic [7:0] wd);
    int w;
    logic fire;
    src_evt = evt; irq_ack = ack; dis_stb = dis; en_stb = en; reti_stb = rt;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    w = best_src(m_pend, m_mask);
    chk("R6 irq_req", {15'd0, irq_req}, {15'd0, m_gie && (w != 0)});
    chk("R4 irq_vec", irq_vec, 16'(w * 2));
    case (a)
      2'd2: chk("R7 vector reg", {8'd0, reg_rdata}, {8'd0, exp_rd(a)});
      2'd3: chk("R8 status reg", {8'd0, reg_rdata}, {8'd0, exp_rd(a)});
      default: chk("R3 mask reg", {8'd0, reg_rdata}, {8'd0, exp_rd(a)});
    endcase
    fire = ack && m_gie && (w != 0);
    @(posedge clk);
    if (fire) m_pend[w-1] = 1'b0;
    m_pend = m_pend | evt;
    if (fire || dis) m_gie = 0;
    else if (en || rt) m_gie = 1;
    if (wr) begin
      if (a == 2'd0) m_mask[7:0] = wd;
      else if (a == 2'd1) m_mask[11:8] = wd[3:0];
    end
    @(negedge clk);
    src_evt = '0; irq_ack = 0; dis_stb = 0; en_stb = 0; reti_stb = 0; reg_wr = 0;
  endtask

  task automatic idle(); step('0, 0, 0, 0, 0, 0, 2'd0, 8'd0); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    // R2 reset state
    repeat (3) @(negedge clk);
    chk("R2 req in reset", {15'd0, irq_req}, 16'd0);
    for (int a = 0; a < 4; a++) peek(2'(a), 8'h00, "R2 reg in reset");
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) peek(2'(a), 8'h00, "R2 reg after reset");

    // R3 masked source pends silently
    step(N'(1) << 4, 0, 0, 0, 0, 0, 2'd3, 8'd0);
    peek(2'd3, 8'h00, "R3 masked sense");
    peek(2'd2, 8'h00, "R3 masked vector");
    step('0, 0, 0, 0, 0, 1, 2'd0, 8'h10);
    peek(2'd3, 8'h80, "R8 sense with gie off");
    peek(2'd2, 8'h0A, "R7 vector src5");
    chk("R6 no req gie off", {15'd0, irq_req}, 16'd0);
    step('0, 0, 0, 1, 0, 0, 2'd3, 8'd0);
    chk("R6 req after enable", {15'd0, irq_req}, 16'd1);
    peek(2'd3, 8'h84, "R9 en strobe");

    // R4 priority
    step((N'(1) << 1) | (N'(1) << 11), 0, 0, 0, 0, 0, 2'd0, 8'd0);
    step('0, 0, 0, 0, 0, 1, 2'd0, 8'h12);
    step('0, 0, 0, 0, 0, 1, 2'd1, 8'h08);
    peek(2'd2, 8'h04, "R4 lowest wins");
    chk("R4 irq_vec src2", irq_vec, 16'h0004);

    // R5 acknowledge
    step('0, 1, 0, 0, 0, 0, 2'd0, 8'd0);
    peek(2'd3, 8'h80, "R5 gie cleared");
    peek(2'd2, 8'h0A, "R5 only winner cleared / R1 src5 held");
    step('0, 1, 0, 0, 0, 0, 2'd0, 8'd0);
    peek(2'd2, 8'h0A, "R6 ack without req ignored");
    step('0, 0, 0, 0, 1, 0, 2'd0, 8'd0);
    peek(2'd3, 8'h84, "R9 reti sets gie");

    // R10 event beats clear
    step(N'(1) << 4, 1, 0, 0, 0, 0, 2'd0, 8'd0);
    peek(2'd2, 8'h0A, "R10 same-cycle event kept");
    peek(2'd3, 8'h80, "R10 gie cleared");
    step('0, 0, 1, 1, 0, 0, 2'd0, 8'd0);
    peek(2'd3, 8'h80, "R9 disable beats enable");
    step('0, 0, 0, 1, 0, 0, 2'd0, 8'd0);
    step('0, 1, 0, 0, 1, 0, 2'd0, 8'd0);
    peek(2'd3, 8'h80, "R9 ack beats reti");

    // R11 read-only addresses
    step('0, 0, 0, 0, 0, 1, 2'd2, 8'hFF);
    step('0, 0, 0, 0, 0, 1, 2'd3, 8'hFF);
    step('0, 0, 0, 0, 0, 1, 2'd1, 8'hF8);
    peek(2'd0, 8'h12, "R11 mask lo intact");
    peek(2'd1, 8'h08, "R11 upper bits read 0");
    peek(2'd3, 8'h80, "R11 status intact");

    // drain: src12 remains
    peek(2'd2, 8'h18, "R4 src12 vector");
    step('0, 0, 0, 1, 0, 0, 2'd0, 8'd0);
    step('0, 1, 0, 0, 0, 0, 2'd0, 8'd0);
    peek(2'd3, 8'h00, "R1 cleared when serviced");

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] ev;
      ev = '0;
      for (int b = 0; b < N; b++) ev[b] = ($urandom % 10) == 0;
      step(ev, ($urandom % 2) == 0, ($urandom % 16) == 0, ($urandom % 4) == 0,
           ($urandom % 8) == 0, ($urandom % 8) == 0, 2'($urandom), 8'($urandom));
    end

    // R2 reset mid-run
    step('1, 0, 0, 1, 0, 1, 2'd0, 8'hFF);
    rst_n = 0;
    @(negedge clk);
    m_pend = '0; m_mask = '0; m_gie = 0;
    rst_n = 1;
    peek(2'd3, 8'h00, "R2 status after reset");
    peek(2'd0, 8'h00, "R2 mask after reset");
    idle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule